// File: doc/BRIEF.md
# Scanline Interrupt Counter with Deferred Reload

This block counts visible display lines and raises a CPU interrupt when an 8-bit down-counter reaches zero. The CPU programs it through a write port decoded on a 16-bit address. One register sets the reload value, one arms the counter and one acknowledges the interrupt. A second register, present only in one build variant, scrambles the reload value as it is stored. The display timing logic delivers a one-cycle tick per line together with the line number and a flag that shows whether rendering is on.

A reload is never applied at the moment it is written. Writing the reload value or arming the block sets a pending-reload flag. The next qualifying line tick copies the stored value into the counter and then takes the usual decrement step. The interrupt line is a level. It stays high until software acknowledges it.

Top module: `scanline_irq_unit`

## Requirements
- R1: Only a tick with `line_tick` high, `render_en` high and `line_num` at most 239 advances the counter or can raise `irq`. Ticks on lines 240 and above, and ticks with rendering off, change nothing.
- R2: On a qualifying tick, a pending reload first copies the stored value into the counter and clears the pending flag. The counter then drops by one if it is nonzero. With stored value L, `irq` therefore rises after max(L,1) qualifying ticks.
- R3: If the counter is zero after a qualifying tick and the interrupt is enabled, `irq` is high from the following clock edge.
- R4: A write that decodes to 0xC002 disables the interrupt and drives `irq` low. While the interrupt stays disabled, further ticks do not raise `irq`.
- R5: A write that decodes to 0xC003 enables the interrupt and sets the pending-reload flag. It does not clear an `irq` that is already high.
- R6: A write that decodes to 0xC005 sets the pending-reload flag and stores a value derived from the data byte d and the scramble register s. If s bit 7 is 1, the stored value is d XOR (s OR 0x01). Otherwise it is d OR (s AND 0x27).
- R7: A write that decodes to 0xC006 loads s only when `OFFSET_EN` is 1. With `OFFSET_EN` 0, s stays 0 and the stored value equals d.
- R8: After reset, `irq` is low and the enable flag, the counter, the stored value, the pending flag and s are all zero.
- R9: Once high, `irq` stays high until an acknowledge write or a reset, regardless of ticks, arming or other writes.
- R10: When a write and a qualifying tick fall in the same cycle, the write takes effect first and the tick then operates on the updated state.
- R11: An address is decoded as `wr_addr & 0xF007`, so 0xCFFA acts as 0xC002. A decoded 0xC004 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse per display line |
| line_num | input | 9 | Number of the line the tick belongs to |
| render_en | input | 1 | High while rendering is on |
| irq | output | 1 | Active-high interrupt level |

## Verification
A CPU write and a qualifying line tick can land in the same clock cycle. The bench forces this by pulsing both strobes together in three cases. In the first, an acknowledge coincides with a tick while the counter sits at zero, and `irq` must end low. In the second, an arm coincides with the tick that loads a stored value of 1, and `irq` must rise, because the interrupt is enabled before the tick is judged. In the third, a reload write lands mid-count together with a tick, and exactly one further tick must then raise `irq`, which shows that the new value was loaded by that same tick.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int unsigned CNT_W = 8;
  localparam logic [15:0] DEC_MASK = 16'hF007;
  localparam logic [15:0] A_ACK    = 16'hC002;
  localparam logic [15:0] A_ARM    = 16'hC003;
  localparam logic [15:0] A_RELOAD = 16'hC005;
  localparam logic [15:0] A_SCRAM  = 16'hC006;

  // Stored reload value derived from the written byte and the scramble register
  function automatic logic [CNT_W-1:0] scramble(input logic [CNT_W-1:0] d,
                                                input logic [CNT_W-1:0] s);
    if (s[CNT_W-1]) return d ^ (s | {{(CNT_W-1){1'b0}}, 1'b1});
    else            return d | (s & 8'h27);
  endfunction

  // Saturating step toward zero
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction
endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter bit OFFSET_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             ack_o,
  output logic             preset_set_o,
  output logic             en_next_o,
  output logic [CNT_W-1:0] reload_next_o
);
  logic [15:0]      dec;
  logic             arm_w, reload_w, scram_w;
  logic             en_q;
  logic [CNT_W-1:0] reload_q, scram_q;

  assign dec      = wr_addr & DEC_MASK;
  assign ack_o    = wr_en && (dec == A_ACK);
  assign arm_w    = wr_en && (dec == A_ARM);
  assign reload_w = wr_en && (dec == A_RELOAD);
  assign scram_w  = wr_en && (dec == A_SCRAM);

  assign preset_set_o  = arm_w | reload_w;
  assign en_next_o     = ack_o ? 1'b0 : (arm_w ? 1'b1 : en_q);
  assign reload_next_o = reload_w ? scramble(wr_data, scram_q) : reload_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      reload_q <= '0;
    end else begin
      en_q     <= en_next_o;
      reload_q <= reload_next_o;
    end
  end

  generate
    if (OFFSET_EN) begin : g_scram
      always_ff @(posedge clk) begin
        if (!rst_n)       scram_q <= '0;
        else if (scram_w) scram_q <= wr_data;
      end
    end else begin : g_noscram
      always_ff @(posedge clk) scram_q <= '0;
    end
  endgenerate

  a_r5_arm_enables: assert property (@(posedge clk) disable iff (!rst_n)
    arm_w |=> en_q);
  a_r4_ack_disables: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !en_q);
  a_r7_scram_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !scram_w |=> $stable(scram_q));
endmodule

// File: rtl/sirq_counter.sv
module sirq_counter
  import sirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual,
  input  logic             preset_set,
  input  logic [CNT_W-1:0] reload_next,
  output logic             zero_evt
);
  logic [CNT_W-1:0] cnt_q, base, cnt_n;
  logic             preset_q, preset_eff;

  assign preset_eff = preset_set | preset_q;
  assign base       = preset_eff ? reload_next : cnt_q;
  assign cnt_n      = step_down(base);
  assign zero_evt   = qual && (cnt_n == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      preset_q <= 1'b0;
    end else if (qual) begin
      cnt_q    <= cnt_n;
      preset_q <= 1'b0;
    end else if (preset_set) begin
      preset_q <= 1'b1;
    end
  end

  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> $stable(cnt_q));
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !preset_eff && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r2_preset_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> !preset_q);
endmodule

// File: rtl/sirq_irq_flag.sv
module sirq_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic fire,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)    irq <= 1'b0;
    else if (ack)  irq <= 1'b0;
    else if (fire) irq <= 1'b1;
  end

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
  import sirq_pkg::*;
#(
  parameter bit          OFFSET_EN = 1'b1,
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned LAST_LINE = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_en,
  output logic              irq
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(LAST_LINE);

  logic             ack, preset_set, en_next, zero_evt, line_qual, fire;
  logic [CNT_W-1:0] reload_next;

  assign line_qual = line_tick && render_en && (line_num <= LAST);
  assign fire      = zero_evt && en_next;

  sirq_ctrl #(.OFFSET_EN(OFFSET_EN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_o(ack), .preset_set_o(preset_set),
    .en_next_o(en_next), .reload_next_o(reload_next));

  sirq_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .qual(line_qual), .preset_set(preset_set),
    .reload_next(reload_next), .zero_evt(zero_evt));

  sirq_irq_flag u_flag (
    .clk(clk), .rst_n(rst_n), .ack(ack), .fire(fire), .irq(irq));

  a_r3_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(line_qual && en_next));
  a_r1_no_rise_off_screen: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_qual && !irq) |=> !irq);
endmodule

// File: tb/scanline_irq_unit_bench.sv
module scanline_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        line_tick = 1'b0;
  logic [8:0]  line_num = '0;
  logic        render_en = 1'b1;
  logic        irq, irq_p;
  int          vectors = 0, miscompares = 0, lc = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  scanline_irq_unit #(.OFFSET_EN(1'b1)) u_scanline_irq_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_tick(line_tick), .line_num(line_num),
    .render_en(render_en), .irq(irq));

  scanline_irq_unit #(.OFFSET_EN(1'b0)) u_scanline_irq_unit_plain (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_tick(line_tick), .line_num(line_num),
    .render_en(render_en), .irq(irq_p));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit w, input logic [15:0] a, input logic [7:0] d,
                       input bit t, input logic [8:0] ln, input bit ren);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d;
    line_tick = t; line_num = ln; render_en = ren;
    @(negedge clk);
    wr_en = 1'b0; line_tick = 1'b0; render_en = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    pulse(1'b1, a, d, 1'b0, 9'd0, 1'b1);
  endtask

  task automatic tick_q();
    pulse(1'b0, 16'h0, 8'h0, 1'b1, 9'(lc), 1'b1);
    lc = (lc + 1) % 240;
  endtask

  task automatic measure(input bit plain, output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      tick_q();
      n++;
      if ((plain ? irq_p : irq) == 1'b1) break;
    end
  endtask

  function automatic int model_reload(input logic [7:0] d, input logic [7:0] s);
    logic [7:0] v;
    v = s[7] ? (d ^ {s[7:1], 1'b1}) : (d | {2'b00, s[5], 2'b00, s[2:0]});
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic run(input logic [7:0] d, input bit plain, output int n);
    wr(16'hC002, 8'h00);
    wr(16'hC005, d);
    wr(16'hC003, 8'h00);
    measure(plain, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] offs [8] = '{8'h00, 8'h27, 8'hFF, 8'h80, 8'h81, 8'h05, 8'h20, 8'h7F};
    logic [7:0] dats [4] = '{8'h00, 8'h10, 8'h55, 8'hC0};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 irq after reset", int'(irq), 0);
    chk("R8 irq after reset (plain)", int'(irq_p), 0);
    // R8: stored value zero -> first qualifying tick after arming fires
    wr(16'hC003, 8'h00);
    measure(1'b0, n);
    chk("R8 zero reload fires on first tick", n, 1);
    // R8: scramble register zero out of reset
    run(8'h10, 1'b0, n);
    chk("R8 scramble zero at reset", n, 16);
    // R2: sweep of every stored value with no scrambling
    for (int l = 0; l < 256; l++) begin
      run(8'(l), 1'b0, n);
      chk("R2 ticks to irq", n, (l == 0) ? 1 : l);
    end
    // R6: scramble rules across offsets and data
    foreach (offs[i]) begin
      wr(16'hC006, offs[i]);
      foreach (dats[j]) begin
        run(dats[j], 1'b0, n);
        chk("R6 scrambled reload", n, model_reload(dats[j], offs[i]));
      end
    end
    // R7: variant without scramble ignores the scramble write
    wr(16'hC006, 8'h27);
    run(8'h10, 1'b1, n);
    chk("R7 plain variant keeps data", n, 16);
    run(8'h10, 1'b0, n);
    chk("R7 scrambling variant applies 0x27", n, 8'h37);
    wr(16'hC006, 8'h00);
    // R1: non-qualifying ticks are ignored
    wr(16'hC002, 8'h00);
    wr(16'hC005, 8'd3);
    wr(16'hC003, 8'h00);
    tick_q();
    pulse(1'b0, 16'h0, 8'h0, 1'b1, 9'd240, 1'b1);
    pulse(1'b0, 16'h0, 8'h0, 1'b1, 9'd261, 1'b1);
    pulse(1'b0, 16'h0, 8'h0, 1'b1, 9'd300, 1'b1);
    pulse(1'b0, 16'h0, 8'h0, 1'b1, 9'd511, 1'b1);
    for (int k = 0; k < 5; k++) pulse(1'b0, 16'h0, 8'h0, 1'b1, 9'(k * 40), 1'b0);
    chk("R1 irq low after ignored ticks", int'(irq), 0);
    measure(1'b0, n);
    chk("R1 counter unchanged by ignored ticks", n, 2);
    // R3: irq high right after the zero step
    chk("R3 irq asserted", int'(irq), 1);
    // R9 and R5: level holds
    repeat (10) @(negedge clk);
    chk("R9 irq holds while idle", int'(irq), 1);
    wr(16'hC003, 8'h00);
    chk("R5 arm keeps pending irq", int'(irq), 1);
    wr(16'hC004, 8'hFF);
    chk("R11 decoded 0xC004 has no effect", int'(irq), 1);
    tick_q(); tick_q(); tick_q();
    chk("R9 irq holds across ticks", int'(irq), 1);
    // R11: mirrored acknowledge address
    wr(16'hCFFA, 8'h00);
    chk("R11 mirrored ack clears irq", int'(irq), 0);
    // R4: disabled interrupt never fires
    tick_q(); tick_q(); tick_q();
    chk("R4 disabled, ticks do not fire", int'(irq), 0);
    // R10a: ack together with a tick on a zero counter
    wr(16'hC005, 8'd1);
    wr(16'hC003, 8'h00);
    tick_q();
    chk("R3 reload 1 fires", int'(irq), 1);
    pulse(1'b1, 16'hC002, 8'h00, 1'b1, 9'd20, 1'b1);
    chk("R10 ack with tick ends low", int'(irq), 0);
    // R10b: arm together with the loading tick
    wr(16'hC005, 8'd1);
    pulse(1'b1, 16'hC003, 8'h00, 1'b1, 9'd21, 1'b1);
    chk("R10 arm with tick fires", int'(irq), 1);
    // R10c: reload write together with a mid-count tick
    wr(16'hC002, 8'h00);
    wr(16'hC005, 8'd9);
    wr(16'hC003, 8'h00);
    tick_q();
    pulse(1'b1, 16'hC005, 8'd2, 1'b1, 9'd22, 1'b1);
    chk("R10 reload with tick, irq still low", int'(irq), 0);
    measure(1'b0, n);
    chk("R10 reload applied by same tick", n, 1);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule